// File: doc/BRIEF.md
# Per-Process Page Table Translator

This block converts a 20-bit virtual address into an 18-bit physical address. Pages are 16 KB, so the upper six address bits pick a page and the lower fourteen bits pass through unchanged. Every process owns a separate 64-entry table held on chip, and a process number presented with each request selects which table is consulted. Because the tables are separate, one process cannot reach a frame that its own table does not name.

Each entry holds a resident flag, a modified flag, a last-use stamp and one shared field. For a resident page that field is the 4-bit frame number. For a page that lives only on disk, the same field holds the disk sector. A lookup that finds a resident page returns the physical address and refreshes the stamp of that entry. A lookup that finds a page on disk raises a fault and returns the sector. Alongside the fault, the block names the resident page of that process that has gone unused the longest, and states whether that page must be written back.

Supervisor logic fills and edits entries through a single-cycle update port. This port is the only way to load the tables. It is also how a page is brought in after a fault is serviced.

Top module: `pt_translator`

## Requirements
- R1: After reset, every response output is 0 and every table entry is non-resident with field 0. A lookup then faults with sector 0 and reports no victim.
- R2: A request strobed at one clock edge produces a response one edge later. `resp_valid` is high for exactly one cycle per request, and the other outputs hold until the next request.
- R3: The table index is vaddr[19:14]. On a resident entry, `resp_hit`=1 and `resp_paddr` = {frame[3:0], vaddr[13:0]}.
- R4: On a non-resident entry, `resp_fault`=1, `resp_hit`=0, and `resp_sector` carries the entry's 12-bit field.
- R5: `req_pid` selects the table. An update to one process's table leaves every other process's translations unchanged.
- R6: A hit with `req_write`=1 sets the entry's modified flag. A read hit leaves the flag unchanged. `victim_dirty` reports the flag of the chosen victim.
- R7: On a fault, the victim is the resident entry of the requesting process with the oldest stamp. Stamps come from a free-running counter, and a hit refreshes the stamp of its entry.
- R8: An entry loaded through the update port gets stamp 0, marking it as never used. Among equal stamps, the lowest page index wins.
- R9: `victim_valid` is 0 on a hit, and also on a fault when the process has no resident entry. When `victim_valid` is 0, `victim_vpn` and `victim_dirty` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_pid | input | 2 | Process selecting the table |
| req_vaddr | input | 20 | Virtual address |
| req_write | input | 1 | Access is a store |
| upd_en | input | 1 | Update-port write strobe |
| upd_pid | input | 2 | Process table to write |
| upd_vpn | input | 6 | Entry index to write |
| upd_valid | input | 1 | New resident flag |
| upd_dirty | input | 1 | New modified flag |
| upd_field | input | 12 | New frame (low 4 bits) or disk sector |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Page resident |
| resp_fault | output | 1 | Page on disk |
| resp_paddr | output | 18 | Physical address on a hit, else 0 |
| resp_sector | output | 12 | Disk sector on a fault, else 0 |
| victim_valid | output | 1 | A victim page is proposed |
| victim_vpn | output | 6 | Page index of the victim |
| victim_dirty | output | 1 | Victim needs write-back |

## Verification
A corrupted entry shows up on the first lookup of that page, one cycle after the strobe. It appears as a wrong frame in `resp_paddr`, or as a hit where a fault was expected, or the reverse. A corrupted stamp or modified flag gives no sign on a hit. It becomes visible only at the next fault in that process, as a wrong `victim_vpn` or `victim_dirty`. The stimulus therefore mixes hits and faults so that every stamp written is later judged by a victim choice. Isolation faults are exposed by lookups of the same page index under different process numbers.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int VA_W   = 20;
    localparam int OFF_W  = 14;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 4;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int SECT_W = 12;
    localparam int FLD_W  = (SECT_W > PPN_W) ? SECT_W : PPN_W;
    localparam int NPROC  = 4;
    localparam int PID_W  = $clog2(NPROC);
    localparam int TS_W   = 16;
    localparam int NPAGES = 1 << VPN_W;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [FLD_W-1:0] field;
        logic [TS_W-1:0]  stamp;
    } pte_t;

    typedef struct packed {
        logic              hit;
        logic              fault;
        logic [PA_W-1:0]   paddr;
        logic [SECT_W-1:0] sector;
        logic              vvalid;
        logic [VPN_W-1:0]  vvpn;
        logic              vdirty;
    } xlat_res_t;

    function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic logic [OFF_W-1:0] off_of(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction
endpackage

// File: rtl/pt_clock.sv
module pt_clock
    import pt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= TS_W'(1);
        else     now <= now + TS_W'(1);
    end
endmodule

// File: rtl/pt_store.sv
module pt_store
    import pt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [PID_W-1:0] upd_pid,
    input  logic [VPN_W-1:0] upd_vpn,
    input  logic             upd_valid,
    input  logic             upd_dirty,
    input  logic [FLD_W-1:0] upd_field,
    input  logic             touch_en,
    input  logic             touch_write,
    input  logic [TS_W-1:0]  now,
    input  logic [PID_W-1:0] rd_pid,
    input  logic [VPN_W-1:0] rd_vpn,
    output pte_t             rd_entry,
    output pte_t             row [NPAGES]
);
    pte_t tbl [NPROC][NPAGES];

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        for (genvar v = 0; v < NPAGES; v++) begin : g_page
            always_ff @(posedge clk) begin
                if (rst) begin
                    tbl[p][v] <= '0;
                end else if (upd_en && upd_pid == PID_W'(p) && upd_vpn == VPN_W'(v)) begin
                    tbl[p][v].valid <= upd_valid;
                    tbl[p][v].dirty <= upd_dirty;
                    tbl[p][v].field <= upd_field;
                    tbl[p][v].stamp <= '0;
                end else if (touch_en && rd_pid == PID_W'(p) && rd_vpn == VPN_W'(v)) begin
                    tbl[p][v].stamp <= now;
                    if (touch_write) tbl[p][v].dirty <= 1'b1;
                end
            end
        end
    end

    assign rd_entry = tbl[rd_pid][rd_vpn];

    always_comb begin
        for (int v = 0; v < NPAGES; v++) row[v] = tbl[rd_pid][v];
    end
endmodule

// File: rtl/pt_lru.sv
module pt_lru
    import pt_pkg::*;
(
    input  pte_t             row [NPAGES],
    output logic             found,
    output logic [VPN_W-1:0] vpn,
    output logic             dirty
);
    logic [TS_W-1:0] best;

    always_comb begin
        found = 1'b0;
        vpn   = '0;
        dirty = 1'b0;
        best  = '1;
        for (int v = 0; v < NPAGES; v++) begin
            if (row[v].valid && (!found || row[v].stamp < best)) begin
                found = 1'b1;
                vpn   = VPN_W'(v);
                dirty = row[v].dirty;
                best  = row[v].stamp;
            end
        end
    end
endmodule

// File: rtl/pt_translator.sv
module pt_translator
    import pt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              upd_en,
    input  logic [PID_W-1:0]  upd_pid,
    input  logic [VPN_W-1:0]  upd_vpn,
    input  logic              upd_valid,
    input  logic              upd_dirty,
    input  logic [FLD_W-1:0]  upd_field,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_fault,
    output logic [PA_W-1:0]   resp_paddr,
    output logic [SECT_W-1:0] resp_sector,
    output logic              victim_valid,
    output logic [VPN_W-1:0]  victim_vpn,
    output logic              victim_dirty
);
    logic [TS_W-1:0]  now;
    pte_t             entry;
    pte_t             row [NPAGES];
    logic             lru_found;
    logic [VPN_W-1:0] lru_vpn;
    logic             lru_dirty;
    xlat_res_t        nxt, res;

    pt_clock u_clock (.clk(clk), .rst(rst), .now(now));

    pt_store u_store (
        .clk(clk), .rst(rst),
        .upd_en(upd_en), .upd_pid(upd_pid), .upd_vpn(upd_vpn),
        .upd_valid(upd_valid), .upd_dirty(upd_dirty), .upd_field(upd_field),
        .touch_en(req_valid && entry.valid), .touch_write(req_write), .now(now),
        .rd_pid(req_pid), .rd_vpn(vpn_of(req_vaddr)),
        .rd_entry(entry), .row(row)
    );

    pt_lru u_lru (.row(row), .found(lru_found), .vpn(lru_vpn), .dirty(lru_dirty));

    always_comb begin
        nxt        = '0;
        nxt.hit    = entry.valid;
        nxt.fault  = !entry.valid;
        if (entry.valid) begin
            nxt.paddr = {entry.field[PPN_W-1:0], off_of(req_vaddr)};
        end else begin
            nxt.sector = entry.field[SECT_W-1:0];
            if (lru_found) begin
                nxt.vvalid = 1'b1;
                nxt.vvpn   = lru_vpn;
                nxt.vdirty = lru_dirty;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            res        <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) res <= nxt;
        end
    end

    assign resp_hit     = res.hit;
    assign resp_fault   = res.fault;
    assign resp_paddr   = res.paddr;
    assign resp_sector  = res.sector;
    assign victim_valid = res.vvalid;
    assign victim_vpn   = res.vvpn;
    assign victim_dirty = res.vdirty;
endmodule

// File: rtl/pt_translator_chk.sv
module pt_translator_chk
    import pt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_fault,
    input logic [PA_W-1:0]   resp_paddr,
    input logic              victim_valid,
    input logic [VPN_W-1:0]  victim_vpn,
    input logic              victim_dirty
);
    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    assert_hold_outputs_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(resp_paddr) && $stable(resp_hit));

    assert_hit_xor_fault_R3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_hit != resp_fault));

    assert_offset_passthru_R3: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_hit |-> resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

    assert_victim_only_on_fault_R9: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> resp_fault);

    assert_victim_zero_when_none_R9: assert property (@(posedge clk) disable iff (rst)
        !victim_valid |-> (victim_vpn == '0 && !victim_dirty));
endmodule

bind pt_translator pt_translator_chk i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .victim_valid(victim_valid),
    .victim_vpn(victim_vpn), .victim_dirty(victim_dirty)
);

// File: tb/test_pt_translator.sv
module test_pt_translator;
    import pt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [PID_W-1:0]  req_pid = '0;
    logic [VA_W-1:0]   req_vaddr = '0;
    logic              req_write = 1'b0;
    logic              upd_en = 1'b0;
    logic [PID_W-1:0]  upd_pid = '0;
    logic [VPN_W-1:0]  upd_vpn = '0;
    logic              upd_valid = 1'b0;
    logic              upd_dirty = 1'b0;
    logic [FLD_W-1:0]  upd_field = '0;
    logic              resp_valid, resp_hit, resp_fault;
    logic [PA_W-1:0]   resp_paddr;
    logic [SECT_W-1:0] resp_sector;
    logic              victim_valid, victim_dirty;
    logic [VPN_W-1:0]  victim_vpn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pt_translator i_pt_translator (.*);

    typedef struct packed {
        logic [1:0]  pid;
        logic [19:0] va;
        logic        wr;
        logic        hit;
        logic [17:0] val;
        logic        vv;
        logic [5:0]  vvpn;
        logic        vd;
    } vec_t;

    // val is the physical address on a hit, the sector on a fault
    localparam vec_t VECS [10] = '{
        '{2'd0, {6'd2, 14'h0000}, 1'b0, 1'b0, 18'h003A7, 1'b1, 6'd0, 1'b0}, // R8 tie -> vpn 0
        '{2'd0, {6'd3, 14'h0CAA}, 1'b0, 1'b1, {4'h2, 14'h0CAA}, 1'b0, 6'd0, 1'b0},
        '{2'd1, {6'd0, 14'h1234}, 1'b0, 1'b1, {4'h2, 14'h1234}, 1'b0, 6'd0, 1'b0},
        '{2'd0, {6'd0, 14'h3FFF}, 1'b1, 1'b1, {4'h9, 14'h3FFF}, 1'b0, 6'd0, 1'b0},
        '{2'd1, {6'd3, 14'h0000}, 1'b0, 1'b0, 18'h00123, 1'b1, 6'd0, 1'b0},  // R5 own table only
        '{2'd0, {6'd5, 14'h0001}, 1'b0, 1'b1, {4'hB, 14'h0001}, 1'b0, 6'd0, 1'b0},
        '{2'd0, {6'd2, 14'h0010}, 1'b0, 1'b0, 18'h003A7, 1'b1, 6'd3, 1'b0},  // R7 oldest vpn 3
        '{2'd2, {6'd0, 14'h0000}, 1'b0, 1'b0, 18'h00000, 1'b0, 6'd0, 1'b0},  // R9 none
        '{2'd0, {6'd3, 14'h2000}, 1'b0, 1'b1, {4'h2, 14'h2000}, 1'b0, 6'd0, 1'b0},
        '{2'd0, {6'd2, 14'h0000}, 1'b0, 1'b0, 18'h003A7, 1'b1, 6'd0, 1'b1}   // R6 R7 dirty victim
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input int pid, input int vpn, input bit v, input bit d, input int fld);
        @(negedge clk);
        upd_en = 1'b1; upd_pid = PID_W'(pid); upd_vpn = VPN_W'(vpn);
        upd_valid = v; upd_dirty = d; upd_field = FLD_W'(fld);
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic lookup(input int pid, input logic [19:0] va, input bit wr);
        @(negedge clk);
        req_valid = 1'b1; req_pid = PID_W'(pid); req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic expect_resp(input string req, input vec_t e);
        chk({req, " resp_valid"}, 32'(resp_valid), 32'd1);
        chk({req, " hit"}, 32'(resp_hit), 32'(e.hit));
        chk({req, " fault"}, 32'(resp_fault), 32'(!e.hit));
        chk({req, " paddr"}, 32'(resp_paddr), e.hit ? 32'(e.val) : 32'd0);
        chk({req, " sector"}, 32'(resp_sector), e.hit ? 32'd0 : 32'(e.val));
        chk({req, " victim_valid"}, 32'(victim_valid), 32'(e.vv));
        chk({req, " victim_vpn"}, 32'(victim_vpn), 32'(e.vvpn));
        chk({req, " victim_dirty"}, 32'(victim_dirty), 32'(e.vd));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        chk("R1 resp_valid", 32'(resp_valid), 0);
        chk("R1 hit", 32'(resp_hit), 0);
        chk("R1 fault", 32'(resp_fault), 0);
        chk("R1 victim_valid", 32'(victim_valid), 0);
        lookup(0, {6'd0, 14'h0100}, 1'b0);
        expect_resp("R1 R4 empty table", '{2'd0, 20'd0, 1'b0, 1'b0, 18'd0, 1'b0, 6'd0, 1'b0});

        // preload: R5 process 0 and 1 tables
        load(0, 0, 1, 0, 9);
        load(0, 2, 0, 0, 12'h3A7);
        load(0, 3, 1, 0, 2);
        load(0, 5, 1, 0, 11);
        load(1, 0, 1, 0, 2);
        load(1, 3, 0, 0, 12'h123);

        foreach (VECS[i]) begin
            lookup(int'(VECS[i].pid), VECS[i].va, VECS[i].wr);
            expect_resp($sformatf("R3 R4 R7 vec%0d", i), VECS[i]);
            @(negedge clk);
            chk($sformatf("R2 pulse vec%0d", i), 32'(resp_valid), 0);
            chk($sformatf("R2 hold vec%0d", i), 32'(resp_paddr), VECS[i].hit ? 32'(VECS[i].val) : 0);
        end

        // R5: updating process 1 leaves process 0 untouched
        load(1, 3, 1, 0, 7);
        lookup(1, {6'd3, 14'h0042}, 1'b0);
        expect_resp("R5 p1 new map", '{2'd1, 20'd0, 1'b0, 1'b1, {4'h7, 14'h0042}, 1'b0, 6'd0, 1'b0});
        lookup(0, {6'd3, 14'h0042}, 1'b0);
        expect_resp("R5 p0 unchanged", '{2'd0, 20'd0, 1'b0, 1'b1, {4'h2, 14'h0042}, 1'b0, 6'd0, 1'b0});

        // R8: reloaded page becomes oldest (stamp 0)
        load(0, 5, 1, 1, 11);
        lookup(0, {6'd2, 14'h0000}, 1'b0);
        expect_resp("R8 reload stamp", '{2'd0, 20'd0, 1'b0, 1'b0, 18'h003A7, 1'b1, 6'd5, 1'b1});

        // R1: reset mid-run clears tables
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 after reset resp_valid", 32'(resp_valid), 0);
        lookup(0, {6'd3, 14'h0042}, 1'b0);
        expect_resp("R1 cleared", '{2'd0, 20'd0, 1'b0, 1'b0, 18'd0, 1'b0, 6'd0, 1'b0});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule